// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tags

This block sits between a serial receiver and the register file of a UART. Every character that the receiver assembles is queued together with three error tags (parity, framing, break) that belong to that character alone, so software that pops a byte also sees exactly the errors that arrived with it. The tags are receive-side only; transmit-side status is kept elsewhere.

The queue holds `DEPTH` entries (16 by default, up to 128) while queueing is enabled, and one entry, acting as a plain holding register, while it is disabled. When the queue is full and nothing is popped, an incoming character is dropped and a sticky overrun flag is raised; the stored characters are left intact. A data-waiting interrupt line and an error-pending flag summarise the contents. Changing the queueing mode empties the queue.

Top module: `rx_status_fifo`

## Requirements
- R1: Characters leave in arrival order. Each entry keeps 8 data bits and 3 tags, presented as rd_status bit 0 = parity error, bit 1 = framing error, bit 2 = break, all taken from the same push as rd_data.
- R2: A push while the queue is full and no pop is requested drops the new character, leaves every stored entry and the level unchanged, and sets overrun on the following clock edge.
- R3: overrun stays set until a cycle with lsr_read high clears it; if a new overrun event and lsr_read occur in the same cycle, overrun stays set.
- R4: With fifo_en high the queue accepts exactly DEPTH entries before full rises; level reports the number of stored entries.
- R5: With fifo_en low the capacity is one entry; a second push without a pop is an overrun.
- R6: data_irq is high exactly when at least one character is stored.
- R7: err_pending is high exactly when at least one stored entry has a nonzero tag field.
- R8: In a cycle where fifo_en differs from the mode in force, all entries are discarded at the next edge, a push or pop in that cycle has no effect and raises no overrun, and the new mode takes effect.
- R9: A push together with a pop on a full queue stores the new character, removes the head, keeps level at capacity and raises no overrun.
- R10: A pop on an empty queue has no effect; while empty, rd_data and rd_status read as zero.
- R11: After reset the queue is empty, overrun and err_pending are low, and the mode in force is the value of fifo_en during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = queue of DEPTH entries, 0 = single holding register |
| wr_valid | input | 1 | Receiver presents a character this cycle |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error tag of the character |
| wr_ferr | input | 1 | Framing error tag of the character |
| wr_brk | input | 1 | Break tag of the character |
| rd_pop | input | 1 | Remove the head entry |
| lsr_read | input | 1 | Line status read; clears the overrun flag |
| rd_data | output | 8 | Head character (zero when empty) |
| rd_status | output | 3 | Head tags: bit 0 parity, bit 1 framing, bit 2 break |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | No entry stored |
| full | output | 1 | Level equals current capacity |
| overrun | output | 1 | Sticky character-lost flag |
| err_pending | output | 1 | Some stored entry carries an error tag |
| data_irq | output | 1 | Received data waiting for the processor |

## Verification
The assertions assume that every input is a clean level sampled at the clock edge and that a mode change is seen as fifo_en differing from the mode register, so a one-cycle toggle produces two flushes. The stimulus only changes inputs on the falling edge, holds fifo_en steady during reset, and exercises pops on an empty queue, pushes on a full queue and mode switches with entries stored, so that every assumed input combination, including the overlapping ones, is reached without ever driving an unknown value.

// File: rtl/rsf_pkg.sv
// Shared types for the receive character queue.
// Assumes: one character is 8 bits and carries exactly three error tags.
package rsf_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;

    // One queue location: tags above the data byte, 11 bits in all.
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rsf_entry_t;
endpackage

// File: rtl/rsf_store.sv
// Circular storage for queue entries with read and write pointers.
// Assumes: push is never asserted when no room exists unless pop is also
// asserted, and pop is never asserted on an empty queue; the controller
// guarantees both. Storage itself is not reset, only the pointers.
module rsf_store #(
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push,
    input  logic                pop,
    input  rsf_pkg::rsf_entry_t wr_entry,
    output rsf_pkg::rsf_entry_t head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rsf_pkg::rsf_entry_t mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Write the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wr_entry;
        end
    end

    // Advance pointers with wrap, or return them to zero on flush/reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
        end
    end

    // Present the oldest entry.
    assign head = mem[rptr];

    // Pointers must never leave the storage range.
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr <= LAST) && (rptr <= LAST));
endmodule

// File: rtl/rsf_ctrl.sv
// Occupancy, mode and flag control for the receive character queue.
// Assumes: inputs are synchronous to clk; a mode change is detected as
// fifo_en differing from the registered mode and costs one flush cycle.
module rsf_ctrl #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_valid,
    input  logic          wr_has_err,
    input  logic          rd_pop,
    input  logic          head_has_err,
    input  logic          lsr_read,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overrun,
    output logic          err_pending
);
    logic          mode_q;
    logic [LW-1:0] cap;
    logic [LW-1:0] err_cnt;
    logic          ovr_evt;

    // Capacity follows the mode in force, not the requested one.
    assign cap   = mode_q ? LW'(DEPTH) : LW'(1);
    assign flush = (fifo_en != mode_q);
    assign full  = (level == cap);
    assign empty = (level == '0);

    // Decide which requests are honoured this cycle.
    always_comb begin
        pop     = rd_pop && !empty && !flush;
        push    = wr_valid && !flush && (!full || pop);
        ovr_evt = wr_valid && !flush && full && !pop;
    end

    // Track the mode in force; take the input value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= fifo_en;
        else        mode_q <= fifo_en;
    end

    // Count stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) level <= '0;
        else                 level <= level + LW'(push) - LW'(pop);
    end

    // Count stored entries that carry an error tag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) err_cnt <= '0;
        else err_cnt <= err_cnt + LW'(push && wr_has_err)
                                - LW'(pop && head_has_err);
    end

    // Sticky overrun: a new event wins over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (ovr_evt)  overrun <= 1'b1;
        else if (lsr_read) overrun <= 1'b0;
    end

    assign err_pending = (err_cnt != '0);

    // Level never exceeds the capacity of the mode in force.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);

    // Single-entry mode holds at most one character.
    assert_single_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> level <= LW'(1));

    // A push onto a full queue without pop raises overrun and keeps level.
    assert_overrun_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_pop && full && (fifo_en == mode_q))
        |=> (overrun && $stable(level)));

    // A status read with no new event clears overrun.
    assert_overrun_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_read && !(wr_valid && !rd_pop && full && (fifo_en == mode_q)))
        |=> !overrun);

    // Mode change empties the queue.
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (level == '0) && !err_pending);

    // Push with pop on a full queue keeps it full and raises no overrun.
    assert_full_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_pop && full && (fifo_en == mode_q) && !overrun)
        |=> ($stable(level) && !overrun));

    // Tagged entries are a subset of stored entries.
    assert_err_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= level);
endmodule

// File: rtl/rx_status_fifo.sv
// Receive character queue: stores each character with its parity, framing
// and break tags, reports overrun, data-waiting and error-pending state.
// Assumes: the receiver presents at most one character per cycle and the
// register interface issues pops and status reads as single-cycle pulses.
module rx_status_fifo #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_perr,
    input  logic          wr_ferr,
    input  logic          wr_brk,
    input  logic          rd_pop,
    input  logic          lsr_read,
    output logic [7:0]    rd_data,
    output logic [2:0]    rd_status,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          overrun,
    output logic          err_pending,
    output logic          data_irq
);
    rsf_pkg::rsf_entry_t wr_entry;
    rsf_pkg::rsf_entry_t head;
    logic push, pop, flush;

    // Pack the incoming character with its tags.
    assign wr_entry = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};

    rsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .wr_valid     (wr_valid),
        .wr_has_err   (wr_perr || wr_ferr || wr_brk),
        .rd_pop       (rd_pop),
        .head_has_err (head.perr || head.ferr || head.brk),
        .lsr_read     (lsr_read),
        .push         (push),
        .pop          (pop),
        .flush        (flush),
        .level        (level),
        .full         (full),
        .empty        (empty),
        .overrun      (overrun),
        .err_pending  (err_pending)
    );

    rsf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .pop      (pop),
        .wr_entry (wr_entry),
        .head     (head)
    );

    // Present the head, masked to zero while nothing is stored.
    always_comb begin
        rd_data   = empty ? 8'h00 : head.data;
        rd_status = empty ? 3'b000 : {head.brk, head.ferr, head.perr};
    end

    assign data_irq = !empty;

    // Error-pending needs at least one stored character.
    assert_err_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pending |-> data_irq);

    // A pop on an empty queue leaves it empty.
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_valid) |=> empty);
endmodule

// File: tb/sim_rx_status_fifo.sv
// Bench: behavioural queue model, compared with the outputs on every cycle.
module sim_rx_status_fifo;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1, wr_valid = 1'b0, rd_pop = 1'b0, lsr_read = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_status;
    logic [LW-1:0] level;
    logic empty, full, overrun, err_pending, data_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R11";

    logic [10:0] mq[$];
    bit m_mode = 1'b1;
    bit m_ovr = 1'b0;

    always #10 clk = ~clk;

    rx_status_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
        .rd_pop(rd_pop), .lsr_read(lsr_read), .rd_data(rd_data),
        .rd_status(rd_status), .level(level), .empty(empty), .full(full),
        .overrun(overrun), .err_pending(err_pending), .data_irq(data_irq)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare();
        int cap = m_mode ? DEPTH : 1;
        bit any_err = 0;
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) any_err = 1;
        chk("level", int'(level), mq.size());
        chk("empty", int'(empty), int'(mq.size() == 0));
        chk("full", int'(full), int'(mq.size() == cap));
        chk("rd_data", int'(rd_data), mq.size() ? int'(mq[0][7:0]) : 0);
        chk("rd_status", int'(rd_status), mq.size() ? int'(mq[0][10:8]) : 0);
        chk("overrun", int'(overrun), int'(m_ovr));
        chk("err_pending", int'(err_pending), int'(any_err));
        chk("data_irq", int'(data_irq), int'(mq.size() != 0));
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(input bit fe, input bit wv, input logic [7:0] d,
                        input logic [2:0] st, input bit pp, input bit lr);
        int cap;
        bit popped, ovr_set;
        fifo_en = fe; wr_valid = wv; wr_data = d;
        wr_perr = st[0]; wr_ferr = st[1]; wr_brk = st[2];
        rd_pop = pp; lsr_read = lr;
        ovr_set = 0;
        if (fe != m_mode) begin
            mq.delete();
            m_mode = fe;
        end else begin
            cap = m_mode ? DEPTH : 1;
            popped = pp && (mq.size() > 0);
            if (popped) void'(mq.pop_front());
            if (wv) begin
                if (mq.size() < cap) mq.push_back({st, d});
                else ovr_set = 1;
            end
        end
        if (ovr_set) m_ovr = 1;
        else if (lr) m_ovr = 0;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(); step(m_mode, 0, 8'h00, 3'b000, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset state with fifo_en high.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R11";
        compare();

        // R1 and R7: ordered data with tags in each position.
        cur_req = "R1";
        step(1, 1, 8'hA5, 3'b000, 0, 0);
        step(1, 1, 8'h3C, 3'b001, 0, 0);
        step(1, 1, 8'h7E, 3'b010, 0, 0);
        step(1, 1, 8'hC3, 3'b100, 0, 0);
        cur_req = "R7";
        step(1, 0, 8'h00, 3'b000, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 8'h00, 3'b000, 1, 0);
        idle();

        // R6: interrupt follows a single character in and out.
        cur_req = "R6";
        step(1, 1, 8'h11, 3'b000, 0, 0);
        step(1, 0, 8'h00, 3'b000, 1, 0);

        // R10: pop on empty.
        cur_req = "R10";
        step(1, 0, 8'h00, 3'b000, 1, 0);
        step(1, 0, 8'h00, 3'b000, 1, 0);

        // R4: fill to capacity.
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++)
            step(1, 1, 8'(8'h20 + i), 3'(i % 5 == 0 ? 3'b010 : 3'b000), 0, 0);

        // R2: push on full is dropped, overrun rises.
        cur_req = "R2";
        step(1, 1, 8'hEE, 3'b111, 0, 0);
        idle();

        // R9: push with pop on full.
        cur_req = "R9";
        step(1, 1, 8'h99, 3'b001, 1, 0);

        // R3: overrun event with a status read in the same cycle stays set,
        // then a plain status read clears it.
        cur_req = "R3";
        step(1, 1, 8'hEF, 3'b000, 0, 1);
        step(1, 0, 8'h00, 3'b000, 0, 1);
        idle();

        // R2: drain to confirm stored entries survived the overruns.
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h00, 3'b000, 1, 0);

        // R8: mode change with entries stored flushes and drops the push.
        cur_req = "R8";
        step(1, 1, 8'h41, 3'b100, 0, 0);
        step(1, 1, 8'h42, 3'b000, 0, 0);
        step(0, 1, 8'h43, 3'b000, 0, 0);

        // R5: single-entry capacity.
        cur_req = "R5";
        step(0, 1, 8'h51, 3'b010, 0, 0);
        step(0, 1, 8'h52, 3'b000, 0, 0);
        step(0, 0, 8'h00, 3'b000, 0, 1);
        step(0, 1, 8'h53, 3'b000, 1, 0);
        step(0, 0, 8'h00, 3'b000, 1, 0);
        cur_req = "R8";
        step(0, 1, 8'h54, 3'b000, 0, 0);
        step(1, 0, 8'h00, 3'b000, 0, 0);

        // Mixed traffic against the model.
        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            bit fe = ($urandom_range(0, 99) < 2) ? !m_mode : m_mode;
            step(fe, $urandom_range(0, 99) < 60, 8'($urandom), 3'($urandom),
                 $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 10);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule